// File: doc/BRIEF.md
# Data Weighted Averaging Element Selector

This block sits between a multibit noise-shaping modulator and a unit-element DAC built from fourteen matched elements. Each clock cycle it accepts one modulator code from 0 to 14. It returns a registered enable vector in which exactly that many elements are switched on.

The elements are not taken from a fixed position. A running pointer marks the first element that has not yet been used. Each sample takes a contiguous run of elements beginning at that pointer, wrapping from the top element back to element 0. The pointer then moves past the run. Over time every element is used equally often, so static element mismatch appears as first-order shaped noise instead of harmonic distortion.

Internally a code is saturated and expanded into a thermometer pattern. The pattern is rotated by the pointer, and the result is captured in an output register in the same cycle that the pointer advances.

Top module: `dwa_element_selector`

## Requirements
- R1: A synchronous active-high reset clears the enable vector to all zeros and sets the pointer to element 0, so the first sample after reset starts at bit 0 of `sel_out`.
- R2: The enable vector is registered: the code present at one rising edge appears as `sel_out` just after that edge and holds until the next edge.
- R3: The number of ones in `sel_out` equals the saturated code value of the sample that produced it.
- R4: Bit i of `sel_out` enables element i. The enabled elements form one contiguous run that begins at the element indexed by the pointer.
- R5: After each sample the pointer advances by the saturated code value, modulo 14, so the next sample starts at the element just above the last one used.
- R6: A run that passes element 13 continues at element 0.
- R7: A code of 0 enables no element and leaves the pointer where it was.
- R8: A code of 14 enables all fourteen elements and leaves the pointer where it was.
- R9: Codes 15 is treated exactly as code 14, both for the enable vector and for the pointer advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 4 | Unsigned modulator code, 0 to 14 valid |
| sel_out | output | 14 | Registered unit-element enables, bit i drives element i |

## Verification
Every code taken at a rising edge shows up as `sel_out` after one register stage, and the pointer that the next code will use settles at the same edge. The driver changes `code_in` on the falling edge and queues the vector that the reference model predicts for the next rising edge. The monitor takes that item off the queue two time units after each rising edge and compares it with `sel_out`, so every comparison falls one cycle after its stimulus. A reset issued mid-stream queues an all-zero vector for the same one-cycle slot and restarts the model pointer at element 0.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
    localparam int DWA_ELEMS  = 14;
    localparam int DWA_CODE_W = $clog2(DWA_ELEMS + 1);
    localparam int DWA_PTR_W  = $clog2(DWA_ELEMS);

    typedef logic [DWA_CODE_W-1:0] dwa_code_t;
    typedef logic [DWA_ELEMS-1:0]  dwa_vec_t;
    typedef logic [DWA_PTR_W-1:0]  dwa_ptr_t;

    // One sample after saturation: its code and its thermometer expansion.
    typedef struct packed {
        dwa_code_t level;
        dwa_vec_t  therm;
    } dwa_sample_t;
endpackage

// File: rtl/dwa_therm_decode.sv
module dwa_therm_decode #(
    parameter int NUM_ELEM = dwa_pkg::DWA_ELEMS,
    localparam int CODE_W  = $clog2(NUM_ELEM + 1)
) (
    input  logic [CODE_W-1:0]   code_raw,
    output logic [CODE_W-1:0]   code_sat,
    output logic [NUM_ELEM-1:0] therm
);
    localparam logic [CODE_W-1:0] FULL = CODE_W'(NUM_ELEM);

    // Out-of-range codes saturate at the full element count.
    assign code_sat = (code_raw > FULL) ? FULL : code_raw;

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_therm
        assign therm[i] = (code_sat > CODE_W'(i));
    end

    always_comb begin
        assert ($countones(therm) == int'(code_sat))
            else $error("assert_therm_count_R3");
    end
endmodule

// File: rtl/dwa_pointer.sv
module dwa_pointer #(
    parameter int NUM_ELEM = dwa_pkg::DWA_ELEMS,
    localparam int CODE_W  = $clog2(NUM_ELEM + 1),
    localparam int PTR_W   = $clog2(NUM_ELEM),
    localparam int SUM_W   = $clog2(2 * NUM_ELEM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] step,
    output logic [PTR_W-1:0]  ptr
);
    localparam logic [SUM_W-1:0] WRAP = SUM_W'(NUM_ELEM);

    logic [SUM_W-1:0] sum;
    logic [PTR_W-1:0] ptr_next;

    // ptr <= NUM_ELEM-1 and step <= NUM_ELEM, so one subtraction suffices.
    always_comb begin
        sum = SUM_W'(ptr) + SUM_W'(step);
        if (sum >= WRAP) ptr_next = PTR_W'(sum - WRAP);
        else             ptr_next = PTR_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else     ptr <= ptr_next;
    end

    assert_ptr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < NUM_ELEM);

    assert_zero_holds_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(step) == '0) |-> ptr == $past(ptr));

    assert_full_holds_ptr_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int'($past(step)) == NUM_ELEM) |-> ptr == $past(ptr));

    assert_reset_ptr_R1: assert property (@(posedge clk)
        $past(rst) |-> ptr == '0);
endmodule

// File: rtl/dwa_rotator.sv
module dwa_rotator #(
    parameter int NUM_ELEM = dwa_pkg::DWA_ELEMS,
    localparam int PTR_W   = $clog2(NUM_ELEM)
) (
    input  logic [NUM_ELEM-1:0] therm,
    input  logic [PTR_W-1:0]    ptr,
    output logic [NUM_ELEM-1:0] rotated
);
    // Element j takes thermometer bit (j - ptr) mod NUM_ELEM, so bit 0 lands on ptr.
    always_comb begin
        for (int j = 0; j < NUM_ELEM; j++) begin
            int k;
            k = j - int'(ptr);
            if (k < 0) k = k + NUM_ELEM;
            rotated[j] = therm[PTR_W'(k)];
        end
    end

    always_comb begin
        assert ($countones(rotated) == $countones(therm))
            else $error("assert_rotate_keeps_count_R3");
    end
endmodule

// File: rtl/dwa_element_selector.sv
module dwa_element_selector #(
    parameter int NUM_ELEM = dwa_pkg::DWA_ELEMS,
    localparam int CODE_W  = $clog2(NUM_ELEM + 1),
    localparam int PTR_W   = $clog2(NUM_ELEM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W-1:0]   code_in,
    output logic [NUM_ELEM-1:0] sel_out
);
    typedef struct packed {
        logic [CODE_W-1:0]   level;
        logic [NUM_ELEM-1:0] therm;
    } sample_t;

    sample_t             smp;
    logic [PTR_W-1:0]    ptr;
    logic [NUM_ELEM-1:0] rotated;
    logic [NUM_ELEM-1:0] sel_q;

    dwa_therm_decode #(.NUM_ELEM(NUM_ELEM)) u_decode (
        .code_raw (code_in),
        .code_sat (smp.level),
        .therm    (smp.therm)
    );

    dwa_pointer #(.NUM_ELEM(NUM_ELEM)) u_pointer (
        .clk  (clk),
        .rst  (rst),
        .step (smp.level),
        .ptr  (ptr)
    );

    dwa_rotator #(.NUM_ELEM(NUM_ELEM)) u_rotator (
        .therm   (smp.therm),
        .ptr     (ptr),
        .rotated (rotated)
    );

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= rotated;
    end

    assign sel_out = sel_q;

    assert_count_matches_code_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(sel_q) == int'($past(smp.level)));

    assert_run_starts_at_ptr_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(smp.level) != '0) |-> sel_q[$past(ptr)]);

    assert_clamp_all_on_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int'($past(code_in)) >= NUM_ELEM) |-> &sel_q);

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> sel_q == '0);
endmodule

// File: tb/sim_dwa_element_selector.sv
module sim_dwa_element_selector;
    localparam int N = 14;

    typedef struct {
        logic [N-1:0] exp;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   code_in = 4'd5;
    logic [N-1:0] sel_out;

    int checks = 0;
    int failures = 0;
    int ptr_m = 0;
    bit done = 0;
    item_t q[$];

    always #5 clk = ~clk;

    dwa_element_selector u0 (
        .clk     (clk),
        .rst     (rst),
        .code_in (code_in),
        .sel_out (sel_out)
    );

    task automatic drive(input logic [3:0] c, input string req);
        item_t it;
        int cs;
        @(negedge clk);
        rst = 1'b0;
        code_in = c;
        cs = (int'(c) > N) ? N : int'(c);
        it.exp = '0;
        for (int i = 0; i < cs; i++) it.exp[(ptr_m + i) % N] = 1'b1;
        it.req = req;
        q.push_back(it);
        ptr_m = (ptr_m + cs) % N;
    endtask

    task automatic drive_reset();
        item_t it;
        @(negedge clk);
        rst = 1'b1;
        code_in = 4'd9;
        it.exp = '0;
        it.req = "R1";
        q.push_back(it);
        ptr_m = 0;
    endtask

    // Monitor: one item is due per rising edge, sampled 2 time units later.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (sel_out !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%b expected=%b", it.req, sel_out, it.exp);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (sel_out !== '0) begin
            failures++;
            $display("FAIL R1 actual=%b expected=%b", sel_out, {N{1'b0}});
        end
        drive(4'd3, "R1");      // first run after reset begins at bit 0
        drive(4'd4, "R2");
        drive(4'd5, "R5");
        drive(4'd6, "R6");      // pointer at 12: wraps past element 13
        drive(4'd6, "R6");
        drive(4'd13, "R6");
        drive(4'd0, "R7");
        drive(4'd1, "R7");      // start shows pointer was unchanged by zero
        drive(4'd14, "R8");
        drive(4'd2, "R8");      // pointer unchanged by full code
        drive(4'd15, "R9");
        drive(4'd15, "R9");
        drive(4'd1, "R9");      // pointer moved as for 14, i.e. not at all
        drive(4'd7, "R4");
        drive_reset();
        drive(4'd2, "R1");
        drive(4'd11, "R4");
        lf = 8'hA5;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            drive(lf[3:0], "R3");
        end
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule